// File: doc/BRIEF.md
# 64-Source Interrupt Gathering Controller

This block collects up to 64 interrupt sources into two 32-bit register halves (high and low) and presents a single request line to the processor. Software reaches it through a simple word-wide register bus. Each half has a pending word and an enable word. A shared edge-select word chooses how the programmable sources are sensed. A read-only vector word names the most urgent active source. Source numbers do not map arithmetically to register bits. A fixed table places each source in a half and at a bit position, and the block applies that table in both directions, to pending readback and to enable lookup.

Every source passes through a two-stage synchroniser followed by one more register that holds the previous synchronised value. A per-source sense mode then decides how the pending bit moves. The modes are:

- OFF: used for the two reserved sources 0 and 31. Pending stays 0.
- LEVEL: pending mirrors the active-low synchronised input every cycle.
- FALL: pending latches on a 1-to-0 transition.
- BOTH: pending latches on any transition.

The transitions out of a latched pending bit in FALL and BOTH are:

- set on a qualifying edge;
- clear on a write of 1 to that bit, unless a new edge arrives in the same cycle;
- hold otherwise.

Internal sources are always in LEVEL. External-pin sources 19 to 25 switch between LEVEL and FALL. Port-C sources 48 to 63 switch between BOTH and FALL.

Top module: `irq_gather64`

## Requirements
- R1: After reset, the enable words, pending words, edge-select word and vector word all read 0, and `cpu_irq` is low.
- R2: Each source is placed by a fixed map:
  - sources 1–15 go to high bits 15..1;
  - sources 32–47 go to high bits 31..16;
  - sources 16–18 go to low bits 2..0;
  - sources 19–30 go to low bits 14..3;
  - sources 48–63 go to low bits 16..31.
  
  Sources 0 and 31 are reserved and never become pending. High bit 0 and low bit 15 always read 0.
- R3: The enable words sit at offset 0x00 (high) and 0x04 (low). They are fully writable and read back what was written. A bit at 1 enables its source.
- R4: In FALL and BOTH mode, pending is sticky. Writing 1 to its bit at 0x08 (high) or 0x0C (low) clears it, writing 0 has no effect, and an edge arriving in the same cycle as the clear wins.
- R5: In LEVEL mode, the pending bit reads 1 exactly while the synchronised input is low, and pending writes do not change it. A change at the input shows in pending after three clock edges.
- R6: An external-pin source s (19–25) is in FALL mode when edge-select bit 33−s is 1 and in LEVEL mode when that bit is 0. In FALL mode it latches only on a 1-to-0 input transition.
- R7: A port-C source s (48–63) uses edge-select bit s−32. At 0 it latches on both edges (BOTH); at 1 it latches only on falling edges (FALL).
- R8: The edge-select word sits at offset 0x10. Only bits 8–14 and 16–31 are writable; all other bits read 0.
- R9: The vector word at 0x14 holds, in bits 31:26, the lowest-numbered source that is both pending and enabled, with all other bits 0. It reads 0 when there is no such source, and writes to it are ignored.
- R10: `cpu_irq` is high exactly when at least one source is both pending and enabled.
- R11: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Active-low interrupt sources, asynchronous to clk |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational from state |
| cpu_irq | output | 1 | Request to the processor |

## Verification
Four groups of stimulus each separate a different fault.

- Single-source sweep: every live source is driven low alone with the edge-select word cleared. The vector and the pending word are checked for each one, which exposes any wrong entry in the half/bit map.
- Sense-mode sequences: an external pin and a port-C source are each toggled under both edge-select settings, with pending writes of 0 and of 1 placed between the edges. This tells level mirroring from sticky latching, falling-only from both-edges, and a real clear from an ignored write.
- Priority tests: two level sources are held together while the enables change. This shows that the lowest number wins and that masking hands the vector to the next source.
- Reserved sources and unmapped offsets: the reserved sources and unmapped offsets are exercised to show they stay inert.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    localparam int NSRC  = 64;
    localparam int DW    = 32;
    localparam int IDX_W = $clog2(NSRC);

    // register byte offsets
    localparam int OFF_EN_HI   = 'h00;
    localparam int OFF_EN_LO   = 'h04;
    localparam int OFF_PEND_HI = 'h08;
    localparam int OFF_PEND_LO = 'h0C;
    localparam int OFF_ESEL    = 'h10;
    localparam int OFF_VEC     = 'h14;

    // edge-select bits that belong to a source (pins 8..14, port C 16..31)
    localparam logic [DW-1:0] ESEL_WMASK = 32'hFFFF_7F00;

    typedef enum logic [1:0] {
        CLS_INTERNAL,
        CLS_EXTPIN,
        CLS_PORTC,
        CLS_RESERVED
    } src_class_e;

    typedef enum logic [1:0] {
        SENSE_OFF,
        SENSE_LEVEL,
        SENSE_FALL,
        SENSE_BOTH
    } sense_e;

    function automatic src_class_e src_class(input int s);
        if (s == 0 || s == 31)        return CLS_RESERVED;
        else if (s >= 19 && s <= 25)  return CLS_EXTPIN;
        else if (s >= 48)             return CLS_PORTC;
        else                          return CLS_INTERNAL;
    endfunction

    // 1 when the source lives in the high half
    function automatic bit src_in_hi(input int s);
        return (s < 16) || (s >= 32 && s < 48);
    endfunction

    // bit position of the source inside its half
    function automatic int src_bitpos(input int s);
        if (s == 0)       return 0;
        else if (s < 16)  return 16 - s;
        else if (s < 19)  return 18 - s;
        else if (s < 31)  return 33 - s;
        else if (s == 31) return 0;
        else if (s < 48)  return 63 - s;
        else              return s - 32;
    endfunction

    // edge-select bit used by a programmable source
    function automatic int esel_pos(input int s);
        if (s >= 19 && s <= 25) return 33 - s;
        else if (s >= 48)       return s - 32;
        else                    return 0;
    endfunction

endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_n,
    output logic [W-1:0] sync_n,
    output logic [W-1:0] prev_n
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '1;
        end else begin
            stg[0] <= din_n;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[i] <= '1;
            end else begin
                stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_n <= '1;
        end else begin
            prev_n <= stg[DEPTH-1];
        end
    end

    assign sync_n = stg[DEPTH-1];

endmodule

// File: rtl/irqg_pend.sv
module irqg_pend
    import irqg_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_n,
    input  logic [N-1:0] prev_n,
    input  sense_e       mode [N],
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar s = 0; s < N; s++) begin : g_bit
        logic pq;
        logic nxt;

        always_comb begin
            unique case (mode[s])
                SENSE_OFF:   nxt = 1'b0;
                SENSE_LEVEL: nxt = ~sync_n[s];
                SENSE_FALL:  nxt = (pq & ~clr[s]) | (prev_n[s] & ~sync_n[s]);
                SENSE_BOTH:  nxt = (pq & ~clr[s]) | (prev_n[s] ^ sync_n[s]);
                default:     nxt = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pq <= 1'b0;
            end else begin
                pq <= nxt;
            end
        end

        assign pend[s] = pq;

        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode[s] == SENSE_FALL || mode[s] == SENSE_BOTH) && pq && !clr[s]) |=> pq); // R4
        AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[s] == SENSE_FALL && !pq && !(prev_n[s] && !sync_n[s])) |=> !pq); // R6
        AST_BOTH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[s] == SENSE_BOTH && !prev_n[s] && sync_n[s]) |=> pq); // R7
        AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[s] == SENSE_OFF) |=> !pq); // R2
    end

endmodule

// File: rtl/irqg_prio.sv
module irqg_prio #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         act,
    output logic [$clog2(N)-1:0] idx
);

    localparam int IW = $clog2(N);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) idx = IW'(i);
        end
    end

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (act & ((N'(1) << idx) - N'(1))) == '0); // R9
    AST_VEC_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> act[idx]); // R9

endmodule

// File: rtl/irq_gather64.sv
module irq_gather64
    import irqg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              cpu_irq
);

    localparam logic [ADDR_W-1:0] A_EN_HI   = ADDR_W'(OFF_EN_HI);
    localparam logic [ADDR_W-1:0] A_EN_LO   = ADDR_W'(OFF_EN_LO);
    localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(OFF_PEND_HI);
    localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(OFF_PEND_LO);
    localparam logic [ADDR_W-1:0] A_ESEL    = ADDR_W'(OFF_ESEL);
    localparam logic [ADDR_W-1:0] A_VEC     = ADDR_W'(OFF_VEC);

    logic [DW-1:0]    en_hi, en_lo, esel_q;
    logic [DW-1:0]    pend_hi_w, pend_lo_w;
    logic [NSRC-1:0]  sync_n, prev_n;
    logic [NSRC-1:0]  pend, en_src, clr_src, act;
    logic [IDX_W-1:0] vec_idx;
    sense_e           mode [NSRC];
    logic             pw_hi, pw_lo;

    assign pw_hi = reg_wr && (reg_addr == A_PEND_HI);
    assign pw_lo = reg_wr && (reg_addr == A_PEND_LO);

    // software-visible configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_hi  <= '0;
            en_lo  <= '0;
            esel_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_EN_HI) en_hi  <= reg_wdata;
            if (reg_addr == A_EN_LO) en_lo  <= reg_wdata;
            if (reg_addr == A_ESEL)  esel_q <= reg_wdata & ESEL_WMASK;
        end
    end

    irqg_sync #(.W(NSRC), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (src_n),
        .sync_n (sync_n),
        .prev_n (prev_n)
    );

    // per-source map between source order and register halves
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam src_class_e CLS   = src_class(s);
        localparam bit         IN_HI = src_in_hi(s);
        localparam int         BP    = src_bitpos(s);
        localparam int         EB    = esel_pos(s);

        if (CLS == CLS_RESERVED) begin : g_rsv
            assign mode[s]    = SENSE_OFF;
            assign en_src[s]  = 1'b0;
            assign clr_src[s] = 1'b0;
        end else begin : g_live
            if (CLS == CLS_EXTPIN) begin : g_ext
                assign mode[s] = esel_q[EB] ? SENSE_FALL : SENSE_LEVEL;
            end else if (CLS == CLS_PORTC) begin : g_pc
                assign mode[s] = esel_q[EB] ? SENSE_FALL : SENSE_BOTH;
            end else begin : g_int
                assign mode[s] = SENSE_LEVEL;
            end

            if (IN_HI) begin : g_hi
                assign en_src[s]     = en_hi[BP];
                assign clr_src[s]    = pw_hi & reg_wdata[BP];
                assign pend_hi_w[BP] = pend[s];
            end else begin : g_lo
                assign en_src[s]     = en_lo[BP];
                assign clr_src[s]    = pw_lo & reg_wdata[BP];
                assign pend_lo_w[BP] = pend[s];
            end
        end
    end

    // bit positions with no source behind them
    assign pend_hi_w[0]  = 1'b0;
    assign pend_lo_w[15] = 1'b0;

    irqg_pend #(.N(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n (sync_n),
        .prev_n (prev_n),
        .mode   (mode),
        .clr    (clr_src),
        .pend   (pend)
    );

    assign act = pend & en_src;

    irqg_prio #(.N(NSRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .idx   (vec_idx)
    );

    assign cpu_irq = |act;

    always_comb begin
        case (reg_addr)
            A_EN_HI:   reg_rdata = en_hi;
            A_EN_LO:   reg_rdata = en_lo;
            A_PEND_HI: reg_rdata = pend_hi_w;
            A_PEND_LO: reg_rdata = pend_lo_w;
            A_ESEL:    reg_rdata = esel_q;
            A_VEC:     reg_rdata = {vec_idx, {(DW-IDX_W){1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end

    AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (vec_idx != '0)); // R10
    AST_ESEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (esel_q & ~ESEL_WMASK) == '0); // R8
    AST_VEC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_VEC) |=> ($stable(en_hi) && $stable(en_lo) && $stable(esel_q))); // R11

endmodule

// File: tb/irq_gather64_tb_top.sv
module irq_gather64_tb_top;

    logic        clk;
    logic        rst_n;
    logic [63:0] src_n;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    irq_gather64 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_n     (src_n),
        .reg_wr    (wr),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .cpu_irq   (irq)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // ---------------- behavioural reference ----------------
    int          ms1 [64];
    int          ms2 [64];
    int          mprev [64];
    int          mpend [64];
    int          npend [64];
    logic [31:0] mehi, melo, mesel;

    function automatic bit f_hi(int s);
        return (s < 16) || (s >= 32 && s < 48);
    endfunction

    function automatic int f_bit(int s);
        if (s < 16)       return (s == 0) ? 0 : 16 - s;
        else if (s <= 18) return 18 - s;
        else if (s <= 30) return 33 - s;
        else if (s == 31) return 0;
        else if (s <= 47) return 63 - s;
        return s - 32;
    endfunction

    // 0 off, 1 level, 2 fall, 3 both
    function automatic int f_mode(int s);
        if (s == 0 || s == 31) return 0;
        if (s >= 19 && s <= 25) return mesel[33 - s] ? 2 : 1;
        if (s >= 48) return mesel[s - 32] ? 2 : 3;
        return 1;
    endfunction

    function automatic bit f_en(int s);
        return f_hi(s) ? mehi[f_bit(s)] : melo[f_bit(s)];
    endfunction

    function automatic int f_vec();
        for (int s = 1; s < 64; s++) begin
            if (mpend[s] != 0 && f_en(s)) return s;
        end
        return 0;
    endfunction

    function automatic logic [31:0] f_pword(bit hi);
        logic [31:0] w = '0;
        for (int s = 1; s < 64; s++) begin
            if (s != 31 && f_hi(s) == hi) w[f_bit(s)] = (mpend[s] != 0);
        end
        return w;
    endfunction

    function automatic logic [31:0] f_read(logic [7:0] a);
        case (a)
            8'h00: return mehi;
            8'h04: return melo;
            8'h08: return f_pword(1'b1);
            8'h0C: return f_pword(1'b0);
            8'h10: return mesel;
            8'h14: return 32'(f_vec()) << 26;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 64; s++) begin
                ms1[s] = 1; ms2[s] = 1; mprev[s] = 1; mpend[s] = 0;
            end
            mehi = '0; melo = '0; mesel = '0;
        end else begin
            for (int s = 0; s < 64; s++) begin
                bit c;
                c = wr && ((addr == 8'h08 && f_hi(s)) || (addr == 8'h0C && !f_hi(s)))
                    && wdata[f_bit(s)];
                case (f_mode(s))
                    1: npend[s] = (ms2[s] == 0) ? 1 : 0;
                    2: npend[s] = ((mpend[s] != 0 && !c) || (mprev[s] == 1 && ms2[s] == 0)) ? 1 : 0;
                    3: npend[s] = ((mpend[s] != 0 && !c) || (mprev[s] != ms2[s])) ? 1 : 0;
                    default: npend[s] = 0;
                endcase
            end
            for (int s = 0; s < 64; s++) begin
                mpend[s] = npend[s];
                mprev[s] = ms2[s];
                ms2[s]   = ms1[s];
                ms1[s]   = int'(src_n[s]);
            end
            if (wr) begin
                case (addr)
                    8'h00: mehi = wdata;
                    8'h04: melo = wdata;
                    8'h10: mesel = wdata & 32'hFFFF_7F00;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string f_tag(logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R3 enable word";
            8'h08, 8'h0C: return "R4 pending word";
            8'h10:        return "R8 edge-select word";
            8'h14:        return "R9 vector word";
            default:      return "R11 unmapped offset";
        endcase
    endfunction

    // compare against the reference on every clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(rdata == f_read(addr), f_tag(addr), rdata, f_read(addr));
            chk(irq == (f_vec() != 0), "R10 cpu_irq", 32'(irq), 32'(f_vec() != 0));
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 8'h14;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic drive(input int s, input logic v);
        @(negedge clk);
        src_n[s] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; src_n = '1; wr = 1'b0; addr = 8'h14; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_exp(8'h00, 32'h0, "R1 enable high");
        rd_exp(8'h04, 32'h0, "R1 enable low");
        rd_exp(8'h08, 32'h0, "R1 pending high");
        rd_exp(8'h0C, 32'h0, "R1 pending low");
        rd_exp(8'h10, 32'h0, "R1 edge-select");
        rd_exp(8'h14, 32'h0, "R1 vector");
        chk(irq == 1'b0, "R1 cpu_irq", 32'(irq), 32'h0);

        // R3 enable words
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        rd_exp(8'h00, 32'hFFFF_FFFF, "R3 enable high");
        rd_exp(8'h04, 32'hFFFF_FFFF, "R3 enable low");

        // R5 internal level source 5 -> high bit 11
        drive(5, 1'b0); settle();
        rd_exp(8'h08, 32'h0000_0800, "R5 level asserted");
        rd_exp(8'h14, 32'd5 << 26, "R9 single source");
        chk(irq == 1'b1, "R10 request high", 32'(irq), 32'h1);
        wr_reg(8'h08, 32'h0000_0800);
        rd_exp(8'h08, 32'h0000_0800, "R5 clear write ignored");
        drive(5, 1'b1); settle();
        rd_exp(8'h08, 32'h0, "R5 level released");

        // R6 external pin 20 in falling mode -> low bit 13
        wr_reg(8'h10, 32'h0000_2000);
        rd_exp(8'h10, 32'h0000_2000, "R8 edge-select bit");
        drive(20, 1'b0); settle();
        rd_exp(8'h0C, 32'h0000_2000, "R6 falling latched");
        drive(20, 1'b1); settle();
        rd_exp(8'h0C, 32'h0000_2000, "R6 sticky after release");
        wr_reg(8'h0C, 32'h0);
        rd_exp(8'h0C, 32'h0000_2000, "R4 write zero no effect");
        wr_reg(8'h0C, 32'h0000_2000);
        rd_exp(8'h0C, 32'h0, "R4 write one clears");

        // R7 port-C 50 -> low bit 18
        drive(50, 1'b0); settle();
        rd_exp(8'h0C, 32'h0004_0000, "R7 both-edge fall");
        wr_reg(8'h0C, 32'h0004_0000);
        rd_exp(8'h0C, 32'h0, "R4 clear port-C");
        drive(50, 1'b1); settle();
        rd_exp(8'h0C, 32'h0004_0000, "R7 both-edge rise");
        wr_reg(8'h0C, 32'h0004_0000);
        wr_reg(8'h10, 32'h0004_2000);
        drive(50, 1'b0); settle();
        rd_exp(8'h0C, 32'h0004_0000, "R7 falling-only fall");
        wr_reg(8'h0C, 32'h0004_0000);
        drive(50, 1'b1); settle();
        rd_exp(8'h0C, 32'h0, "R7 falling-only rise ignored");

        // R9 priority between sources 10 and 40
        drive(40, 1'b0); drive(10, 1'b0); settle();
        rd_exp(8'h14, 32'd10 << 26, "R9 lowest number wins");
        wr_reg(8'h00, ~32'h0000_0040);
        rd_exp(8'h14, 32'd40 << 26, "R9 masked source skipped");
        wr_reg(8'h00, 32'h0);
        wr_reg(8'h04, 32'h0);
        rd_exp(8'h14, 32'h0, "R9 nothing enabled");
        chk(irq == 1'b0, "R10 request low when masked", 32'(irq), 32'h0);
        rd_exp(8'h08, 32'h0080_0040, "R2 high word bits for 10 and 40");
        drive(40, 1'b1); drive(10, 1'b1); settle();

        // R8 writable edge-select bits
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_exp(8'h10, 32'hFFFF_7F00, "R8 reserved bits zero");

        // R2 reserved sources
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        drive(0, 1'b0); drive(31, 1'b0); settle();
        rd_exp(8'h08, 32'h0, "R2 source 0 ignored");
        rd_exp(8'h0C, 32'h0, "R2 source 31 ignored");
        rd_exp(8'h14, 32'h0, "R2 reserved no vector");
        drive(0, 1'b1); drive(31, 1'b1); settle();

        // R11 unmapped offsets and read-only vector
        rd_exp(8'h18, 32'h0, "R11 read unmapped");
        rd_exp(8'h02, 32'h0, "R11 read misaligned");
        wr_reg(8'h18, 32'hFFFF_FFFF);
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_exp(8'h00, 32'hFFFF_FFFF, "R11 enable untouched");
        rd_exp(8'h10, 32'hFFFF_7F00, "R11 edge-select untouched");
        rd_exp(8'h14, 32'h0, "R9 vector read-only");

        // R2 map sweep with default senses
        wr_reg(8'h10, 32'h0);
        for (int s = 1; s < 64; s++) begin
            if (s != 31) begin
                drive(s, 1'b0); settle();
                rd_exp(8'h14, 32'(s) << 26, "R2 map vector");
                rd_exp(f_hi(s) ? 8'h08 : 8'h0C, 32'h1 << f_bit(s), "R2 map bit");
                drive(s, 1'b1); settle();
                wr_reg(8'h08, 32'hFFFF_FFFF);
                wr_reg(8'h0C, 32'hFFFF_FFFF);
            end
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule